// File: doc/BRIEF.md
# Watchdog and Periodic Interrupt Timebase

This block pairs a software-serviced watchdog with a periodic interrupt generator. Both take their timing from one free-running binary divider that advances on every system clock (E) cycle. The watchdog counts coarse base periods taken from a divider tap. If the host does not service it in time, the block raises a one-cycle reset request. Servicing is a two-step key exchange on a service register. An arming key must come first and a clearing key second, so a runaway program that writes one fixed value cannot keep the watchdog alive.

The periodic generator sets a sticky flag each time a selected divider tap rolls over. The host clears the flag by writing a one to it. An enable bit gates the flag onto the interrupt request pin. The watchdog rate field is write-protected: in normal mode it accepts one write, and only inside a short window after reset. In special mode it accepts writes at any time. A strap input turns off the reset request.

The register port is a plain single-cycle synchronous port. A write takes effect on the clock edge that samples `bus_we`, and read data is a combinational function of `bus_addr`. No stream carries data through the block, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

Top module: `wdt_timebase`

## Requirements
- R1: Writing 0x55 and then 0xAA to the service register (address 0) clears the watchdog count. The clear takes effect on the edge that samples the 0xAA write, and that write consumes the arming. A further 0xAA without a new 0x55 clears nothing.
- R2: A 0xAA that is not preceded by an arming 0x55 does not clear the count. Bytes other than 0x55 and 0xAA leave the armed state as it was, and a repeated 0x55 keeps it armed.
- R3: Let P = 2^BASE_LOG2 cycles, and let N be 1, 4, 16 or 64 for watchdog rate codes 00, 01, 10 and 11. Count edges from reset release. If the last reference event (reset release as edge 0, a clear, or a previous reset request) was at edge c, the reset request is seen after edge (floor(c/P) + N + 1)·P. This gives a timeout of more than N·P and at most (N+1)·P cycles.
- R4: While `wd_disable` is 1, no reset request is issued and the count is held at zero. The last edge that samples the strap high therefore acts as a clear.
- R5: In normal mode, the watchdog rate field (control register, address 1, bits [1:0]) accepts a write only on clock edges 1 through WIN_CYCLES counted from reset release or from a reset request. Later writes leave it unchanged.
- R6: In normal mode, only the first accepted write to the watchdog rate field takes effect. Later writes leave it unchanged, while the periodic fields of the same register stay writable.
- R7: In special mode, the watchdog rate field accepts every write at any time.
- R8: The periodic flag (address 2, bit 0) is set after every edge that is a multiple of 2^(PI_BASE_LOG2+k) cycles from reset release, where k is the periodic rate code in control bits [5:4].
- R9: Writing 1 to bit 0 of address 2 clears the periodic flag, and writing 0 there leaves it as it was. If a set and a clear fall on the same edge, the set wins.
- R10: `pi_irq` is high exactly when the periodic flag is set and the enable bit (control bit 7) is 1.
- R11: The reset request lasts one cycle. On the same edge the count, the armed state, the rate field, the write-once lock and the write window all return to their reset values.
- R12: Out of reset, both outputs are 0, the control and flag registers read 0x00, and the service register always reads 0x00. Control bits [6] and [3:2] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System E clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| special_mode | input | 1 | 1 lifts the write protection on the watchdog rate field |
| wd_disable | input | 1 | Strap; 1 suppresses the watchdog reset request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 service, 1 control, 2 flags |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| wd_reset_req | output | 1 | One-cycle watchdog reset request |
| pi_irq | output | 1 | Periodic interrupt request |

## Verification
The watchdog is tried with every rate code after a reset request, and with key streams that differ only in order, in stray bytes and in a repeated clearing key. Each expiry edge is predicted from the floor formula, so a clear that happened and a clear that did not land on different multiples of P. The write window is probed on its last open edge and its first closed edge, and write-once and special mode are tried against the same field. For every periodic rate, both the alignment of the first set and the spacing of the next set are checked, which separates a wrong tap from a wrong phase. Write-zero, masking and same-register writes after the lock complete the checks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RATE_W = 2;
  localparam int NUM_RATES = 1 << RATE_W;

  localparam logic [1:0] ADDR_KEY   = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;

  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_CLEAR = 8'hAA;

  typedef struct packed {
    logic              pi_en;
    logic              rsv_hi;
    logic [RATE_W-1:0] pi_rate;
    logic [1:0]        rsv_lo;
    logic [RATE_W-1:0] wd_rate;
  } ctrl_t;
endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int BASE_LOG2    = 15,
  parameter int PI_BASE_LOG2 = 13,
  parameter int PI_RATES     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                base_tick,
  output logic [PI_RATES-1:0] pi_tick
);
  localparam int PI_TOP = PI_BASE_LOG2 + PI_RATES - 1;
  localparam int DIV_W  = (BASE_LOG2 > PI_TOP) ? BASE_LOG2 : PI_TOP;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_W'(1);
  end

  // A tap is active in the last cycle before its stage rolls over.
  assign base_tick = &div_q[BASE_LOG2-1:0];

  generate
    for (genvar k = 0; k < PI_RATES; k++) begin : g_tap
      assign pi_tick[k] = &div_q[PI_BASE_LOG2+k-1:0];
    end
  endgenerate
endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog
  import wdt_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  parameter int STEP_LOG2  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              wd_disable,
  input  logic              base_tick,
  input  logic              key_we,
  input  logic [7:0]        key_data,
  input  logic              rate_we,
  input  logic [RATE_W-1:0] rate_data,
  output logic [RATE_W-1:0] wd_rate,
  output logic              wd_locked,
  output logic              reset_req
);
  localparam int MAX_DIV = 1 << (STEP_LOG2 * (NUM_RATES - 1));
  localparam int CNT_W   = $clog2(MAX_DIV + 1);
  localparam int WIN_W   = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q, limit;
  logic [WIN_W-1:0]  win_q;
  logic [RATE_W-1:0] rate_q;
  logic              armed_q, locked_q, req_q;
  logic              win_open, rate_ok, do_clear, expire;

  always_comb begin
    limit    = CNT_W'(1) << (rate_q * STEP_LOG2);
    win_open = (win_q < WIN_W'(WIN_CYCLES));
    rate_ok  = rate_we && (special_mode || (win_open && !locked_q));
    do_clear = key_we && (key_data == KEY_CLEAR) && armed_q;
    expire   = base_tick && (cnt_q >= limit) && !do_clear && !wd_disable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      win_q    <= '0;
      rate_q   <= '0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      req_q    <= 1'b0;
    end else if (expire) begin
      cnt_q    <= '0;
      win_q    <= '0;
      rate_q   <= '0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      req_q    <= 1'b1;
    end else begin
      req_q <= 1'b0;
      if (win_open) win_q <= win_q + WIN_W'(1);
      if (rate_ok) begin
        rate_q <= rate_data;
        if (!special_mode) locked_q <= 1'b1;
      end
      if (key_we) begin
        if (key_data == KEY_ARM)        armed_q <= 1'b1;
        else if (key_data == KEY_CLEAR) armed_q <= 1'b0;
      end
      if (do_clear || wd_disable) cnt_q <= '0;
      else if (base_tick)         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign wd_rate   = rate_q;
  assign wd_locked = locked_q;
  assign reset_req = req_q;
endmodule

// File: rtl/wdt_periodic.sv
module wdt_periodic (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr_we,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (tick)   flag <= 1'b1;
    else if (clr_we) flag <= 1'b0;
  end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2    = 15,
  parameter int PI_BASE_LOG2 = 13,
  parameter int WIN_CYCLES   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       wd_disable,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wd_reset_req,
  output logic       pi_irq
);
  logic                 base_tick;
  logic [NUM_RATES-1:0] pi_tick;
  logic                 pi_tick_sel;
  logic                 pi_flag;
  logic [RATE_W-1:0]    wd_rate;
  logic                 wd_locked;
  logic [RATE_W-1:0]    pi_rate_q;
  logic                 pi_en_q;
  logic                 we_key, we_ctrl, we_flags;
  ctrl_t                wr_ctrl, rd_ctrl;

  assign we_key   = bus_we && (bus_addr == ADDR_KEY);
  assign we_ctrl  = bus_we && (bus_addr == ADDR_CTRL);
  assign we_flags = bus_we && (bus_addr == ADDR_FLAGS);
  assign wr_ctrl  = ctrl_t'(bus_wdata);

  wdt_divider #(
    .BASE_LOG2   (BASE_LOG2),
    .PI_BASE_LOG2(PI_BASE_LOG2),
    .PI_RATES    (NUM_RATES)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_tick(base_tick),
    .pi_tick  (pi_tick)
  );

  wdt_watchdog #(
    .WIN_CYCLES(WIN_CYCLES)
  ) u_wd (
    .clk         (clk),
    .rst_n       (rst_n),
    .special_mode(special_mode),
    .wd_disable  (wd_disable),
    .base_tick   (base_tick),
    .key_we      (we_key),
    .key_data    (bus_wdata),
    .rate_we     (we_ctrl),
    .rate_data   (wr_ctrl.wd_rate),
    .wd_rate     (wd_rate),
    .wd_locked   (wd_locked),
    .reset_req   (wd_reset_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_rate_q <= '0;
      pi_en_q   <= 1'b0;
    end else if (we_ctrl) begin
      pi_rate_q <= wr_ctrl.pi_rate;
      pi_en_q   <= wr_ctrl.pi_en;
    end
  end

  assign pi_tick_sel = pi_tick[pi_rate_q];

  wdt_periodic u_pi (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pi_tick_sel),
    .clr_we(we_flags && bus_wdata[0]),
    .flag  (pi_flag)
  );

  assign pi_irq = pi_flag && pi_en_q;

  always_comb begin
    rd_ctrl         = '0;
    rd_ctrl.pi_en   = pi_en_q;
    rd_ctrl.pi_rate = pi_rate_q;
    rd_ctrl.wd_rate = wd_rate;
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = rd_ctrl;
      ADDR_FLAGS: bus_rdata = {7'd0, pi_flag};
      default:    bus_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/wdt_timebase_chk.sv
module wdt_timebase_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic              wd_disable,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic              bus_wdata0,
  input logic              wd_reset_req,
  input logic              pi_flag,
  input logic              pi_tick_sel,
  input logic [RATE_W-1:0] wd_rate,
  input logic              wd_locked
);
  p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |=> !wd_reset_req);

  p_req_clears_rate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |-> (wd_rate == '0) && !wd_locked);

  p_strap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_disable) |-> !wd_reset_req);

  p_rate_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && wd_locked && bus_we && bus_addr == ADDR_CTRL)
      |=> (wd_rate == $past(wd_rate)) || wd_reset_req);

  p_flag_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_FLAGS && bus_wdata0 && !pi_tick_sel) |=> !pi_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_flag && !(bus_we && bus_addr == ADDR_FLAGS && bus_wdata0)) |=> pi_flag);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pi_tick_sel |=> pi_flag);
endmodule

bind wdt_timebase wdt_timebase_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .special_mode(special_mode),
  .wd_disable  (wd_disable),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata0  (bus_wdata[0]),
  .wd_reset_req(wd_reset_req),
  .pi_flag     (pi_flag),
  .pi_tick_sel (pi_tick_sel),
  .wd_rate     (wd_rate),
  .wd_locked   (wd_locked)
);

// File: tb/test_wdt_timebase.sv
`timescale 1ns/1ps
module test_wdt_timebase;
  localparam int BL = 4;
  localparam int PL = 3;
  localparam int P  = 1 << BL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       wd_disable = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       wd_reset_req, pi_irq;

  int cyc;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  wdt_timebase #(.BASE_LOG2(BL), .PI_BASE_LOG2(PL), .WIN_CYCLES(64)) i_wdt_timebase (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wd_disable(wd_disable),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_reset_req(wd_reset_req), .pi_irq(pi_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expiry(input int c, input int n);
    return (c / P + n + 1) * P;
  endfunction

  task automatic do_reset(input bit sm, input bit dis);
    @(negedge clk);
    rst_n = 1'b0;
    bus_we = 1'b0;
    special_mode = sm;
    wd_disable = dis;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_at(input int edge_no, input logic [1:0] a, input logic [7:0] d);
    while (cyc < edge_no - 1) @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_pulse(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (wd_reset_req) begin
        t = cyc;
        break;
      end
    end
    @(negedge clk);
    chk(!wd_reset_req, "R11 request lasts one cycle", int'(wd_reset_req), 0);
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 500; i++) begin
      if (pi_irq) begin
        t = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, t, e0, t1, t2, x;

    // ---- reset state and first timeout (R12, R3) ----
    do_reset(1'b0, 1'b0);
    chk(!wd_reset_req && !pi_irq, "R12 outputs after reset", int'(wd_reset_req) + int'(pi_irq), 0);
    rd(2'd1, v); chk(v == 0, "R12 control reads 0", v, 0);
    rd(2'd2, v); chk(v == 0, "R12 flags read 0", v, 0);
    rd(2'd0, v); chk(v == 0, "R12 service reads 0", v, 0);
    wait_pulse(t);
    chk(t == expiry(0, 1), "R3 first timeout from reset", t, expiry(0, 1));
    e0 = t;

    // ---- every watchdog rate code after a request (R3, R5, R11) ----
    for (int k = 0; k < 4; k++) begin
      int n;
      n = 1 << (2 * k);
      rd(2'd1, v);
      chk(v == 0, "R11 rate back to 00 after request", v, 0);
      wr_at(e0 + 3, 2'd1, 8'(k));
      rd(2'd1, v);
      chk(v == k, "R5 rate accepted in window", v, k);
      wait_pulse(t);
      chk(t == expiry(e0, n), "R3 timeout per rate code", t, expiry(e0, n));
      e0 = t;
    end

    // ---- key orderings, rate 00 (R1, R2) ----
    wr_at(e0 + 18, 2'd0, 8'h55);
    wr_at(e0 + 20, 2'd0, 8'hAA);
    wait_pulse(t);
    chk(t == expiry(e0 + 20, 1), "R1 arm then clear", t, expiry(e0 + 20, 1));
    e0 = t;

    wr_at(e0 + 20, 2'd0, 8'hAA);
    wait_pulse(t);
    chk(t == expiry(e0, 1), "R2 lone clear key ignored", t, expiry(e0, 1));
    e0 = t;

    wr_at(e0 + 18, 2'd0, 8'h55);
    wr_at(e0 + 19, 2'd0, 8'h12);
    wr_at(e0 + 20, 2'd0, 8'hAA);
    wait_pulse(t);
    chk(t == expiry(e0 + 20, 1), "R2 stray byte keeps arm", t, expiry(e0 + 20, 1));
    e0 = t;

    wr_at(e0 + 18, 2'd0, 8'hAA);
    wr_at(e0 + 20, 2'd0, 8'h55);
    wait_pulse(t);
    chk(t == expiry(e0, 1), "R2 reversed order no clear", t, expiry(e0, 1));
    e0 = t;

    wr_at(e0 + 17, 2'd0, 8'h55);
    wr_at(e0 + 18, 2'd0, 8'hAA);
    wr_at(e0 + 34, 2'd0, 8'hAA);
    wait_pulse(t);
    chk(t == expiry(e0 + 18, 1), "R1 clear consumes the arming", t, expiry(e0 + 18, 1));
    e0 = t;

    wr_at(e0 + 18, 2'd0, 8'h55);
    wr_at(e0 + 19, 2'd0, 8'h55);
    wr_at(e0 + 20, 2'd0, 8'hAA);
    wait_pulse(t);
    chk(t == expiry(e0 + 20, 1), "R2 repeated arm still clears", t, expiry(e0 + 20, 1));
    e0 = t;

    // ---- disable strap (R4) ----
    wd_disable = 1'b1;
    v = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wd_reset_req) v++;
    end
    chk(v == 0, "R4 no request while strapped", v, 0);
    x = cyc;
    wd_disable = 1'b0;
    wait_pulse(t);
    chk(t == expiry(x, 1), "R4 strap holds count at zero", t, expiry(x, 1));

    // ---- write window and write-once (R5, R6) ----
    do_reset(1'b0, 1'b1);
    wr_at(64, 2'd1, 8'h02);
    rd(2'd1, v); chk(v == 2, "R5 write on last window edge", v, 2);
    wr_at(70, 2'd1, 8'h01);
    rd(2'd1, v); chk(v == 2, "R6 second write rejected", v, 2);
    wr_at(72, 2'd1, 8'hB1);
    rd(2'd1, v); chk(v == 8'hB2, "R6 periodic fields still writable", v, 8'hB2);

    do_reset(1'b0, 1'b1);
    wr_at(65, 2'd1, 8'h03);
    rd(2'd1, v); chk(v == 0, "R5 write after window rejected", v, 0);

    do_reset(1'b0, 1'b1);
    wr_at(5, 2'd1, 8'h01);
    wr_at(10, 2'd1, 8'h03);
    rd(2'd1, v); chk(v == 1, "R6 early second write rejected", v, 1);

    // ---- special mode (R7) ----
    do_reset(1'b1, 1'b1);
    wr_at(100, 2'd1, 8'h03);
    rd(2'd1, v); chk(v == 3, "R7 late write accepted", v, 3);
    wr_at(110, 2'd1, 8'h01);
    rd(2'd1, v); chk(v == 1, "R7 rewrite accepted", v, 1);

    // ---- periodic flag sweep (R8, R9, R10) ----
    for (int k = 0; k < 4; k++) begin
      int m;
      m = 1 << (PL + k);
      wr_now(2'd1, 8'h80 | 8'(k << 4));
      wr_now(2'd2, 8'h01);
      wait_irq(t1);
      chk(t1 > 0 && t1 % m == 0, "R8 set aligned to tap", t1, (t1 / m) * m);
      wr_now(2'd2, 8'h01);
      rd(2'd2, v); chk(v == 0, "R9 write one clears", v, 0);
      wait_irq(t2);
      chk(t2 - t1 == m, "R8 period per rate code", t2 - t1, m);
      wr_now(2'd2, 8'hFE);
      rd(2'd2, v); chk(v == 1, "R9 write zero keeps flag", v, 1);
      wr_now(2'd1, 8'(k << 4));
      chk(!pi_irq, "R10 request masked when disabled", int'(pi_irq), 0);
      rd(2'd2, v); chk(v == 1, "R10 flag kept under mask", v, 1);
      wr_now(2'd2, 8'h01);
      rd(2'd2, v); chk(v == 0, "R9 clear under mask", v, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule